// File: doc/BRIEF.md
# SDRAM Write Burst Capture Engine

This engine sits on the device side of a single-data-rate SDRAM interface and turns already-decoded commands into write strobes for a storage array of four banks, each 512K words of 32 bits (2048 rows of 256 columns). An activate command records which row each bank has open. A write command then starts a burst whose first data word is taken on the very clock edge that registers the command. Each later word is taken on the next edges, at column addresses that the engine generates.

The burst length is chosen per write by a 3-bit code: 1, 2, 4 or 8 beats, or a full-page burst that wraps around the row until a terminate command or a new write stops it. A new write may arrive on any cycle and takes over at once, with no idle gap. A per-byte mask suppresses lanes beat by beat. A write that asks for auto precharge produces a one-cycle precharge request for its bank when its final beat is written, and that bank's row is then closed.

Every captured beat shows up as a registered strobe one cycle after the edge that captured it. The strobe carries bank, row, column, masked data and byte enables.

Top module: `sdr_wb_engine`

## Requirements
- R1: Command encoding on `cmd` is 00 no-op, 01 activate, 10 write, 11 burst terminate. A write to a bank with an open row captures `dq` on the edge of the command, and in the next cycle `wr_en` is high with `wr_bank` = `bank`, `wr_col` = `addr[7:0]`, and `wr_row` = the row last activated in that bank.
- R2: `bl_code` is sampled with the write. Values 0, 1, 2 and 3 give 1, 2, 4 and 8 beats; any value with bit 2 set gives a full-page burst. After the first beat, one further beat is captured on each following edge.
- R3: Within a fixed burst, column bits [log2(length)-1:0] count up from the start column modulo the length, and the upper column bits stay fixed. For example, a 4-beat burst starting at column 0x0E writes 0x0E, 0x0F, 0x0C, 0x0D.
- R4: After the last beat of a fixed burst, `wr_en` stays low and `dq` is ignored until the next accepted write.
- R5: A full-page burst increments the column on every edge, goes from column 255 back to column 0 in the same row, and never ends by itself.
- R6: An accepted write on any cycle ends the burst in progress at once. The data on that edge belongs to the new burst, whether the new write targets the same bank or another one.
- R7: `dqm` bit i set on a beat makes `wr_be[i]` low and `wr_data` byte i zero for that beat only. The burst still advances its column.
- R8: A burst terminate command stops the current burst. The word on that edge is not written, so `wr_en` is low in the next cycle.
- R9: For a write with `auto_pre` set, `pre_req` is high and `pre_bank` names the bank in the same cycle as the strobe of the burst's final beat, and that bank's row is closed. A burst that is truncated or terminated requests no precharge.
- R10: A write to a bank with no open row raises `wr_err` for one cycle and is otherwise ignored: it neither starts a burst nor disturbs one in progress.
- R11: After reset, every bank is closed and `wr_en`, `pre_req` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Decoded command (00 no-op, 01 activate, 10 write, 11 terminate) |
| bank | input | 2 | Bank for activate or write |
| addr | input | 11 | Row for activate; column in bits [7:0] for write |
| auto_pre | input | 1 | Auto-precharge request carried by a write |
| bl_code | input | 3 | Burst length code sampled with a write |
| dq | input | 32 | Write data word |
| dqm | input | 4 | Per-byte mask, 1 blocks the byte |
| wr_en | output | 1 | Array write strobe |
| wr_bank | output | 2 | Bank of the strobed beat |
| wr_row | output | 11 | Row of the strobed beat |
| wr_col | output | 8 | Column of the strobed beat |
| wr_data | output | 32 | Data with masked bytes zeroed |
| wr_be | output | 4 | Byte enables of the strobed beat |
| pre_req | output | 1 | One-cycle precharge request |
| pre_bank | output | 2 | Bank to precharge |
| wr_err | output | 1 | Write to a closed bank was rejected |

## Verification
The properties assume exactly one decoded command per edge. They also assume `bank` and `addr` are meaningful only alongside an activate or a write, and that the array accepts a strobe every cycle without back-pressure. The stimulus drives all inputs on the falling edge, so each command is seen by exactly one rising edge. It opens rows before writing, except in the deliberate closed-bank cases, and it keeps reset asserted for several cycles before the first command. The random phase draws only the four legal command codes and full-range burst codes, so mid-burst activates, rejected writes and reopening after auto precharge all occur inside those assumptions.

// File: rtl/sdr_wb_pkg.sv
package sdr_wb_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_WR  = 2'b10,
    CMD_BST = 2'b11
  } wb_cmd_e;

  // burst-length code helpers: bit 2 selects full page, bits 1:0 are log2(beats)
  function automatic logic code_is_page(input logic [2:0] code);
    return code[2];
  endfunction

  function automatic logic [1:0] code_log(input logic [2:0] code);
    return code[1:0];
  endfunction

  function automatic logic [3:0] code_beats(input logic [2:0] code);
    return 4'd1 << code[1:0];
  endfunction

endpackage

// File: rtl/wb_row_track.sv
module wb_row_track #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    act_en,
  input  logic [BANK_W-1:0]       act_bank,
  input  logic [ROW_W-1:0]        act_row,
  input  logic                    close_en,
  input  logic [BANK_W-1:0]       close_bank,
  output logic [BANKS-1:0]        open_vec,
  output logic [BANKS*ROW_W-1:0]  row_flat
);

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (act_en && act_bank == BANK_W'(gi)) begin
        open_q <= 1'b1;
        row_q  <= act_row;
      end else if (close_en && close_bank == BANK_W'(gi)) begin
        open_q <= 1'b0;
      end
    end

    assign open_vec[gi]                   = open_q;
    assign row_flat[gi*ROW_W +: ROW_W]    = row_q;
  end

endmodule

// File: rtl/wb_burst_seq.sv
module wb_burst_seq
  import sdr_wb_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [BANK_W-1:0] st_bank,
  input  logic [ROW_W-1:0]  st_row,
  input  logic [COL_W-1:0]  st_col,
  input  logic [2:0]        st_code,
  input  logic              st_ap,
  output logic              beat_vld,
  output logic              beat_last,
  output logic              beat_ap,
  output logic [BANK_W-1:0] beat_bank,
  output logic [ROW_W-1:0]  beat_row,
  output logic [COL_W-1:0]  beat_col,
  output logic              busy
);

  // next column: low bits selected by the mask count up, the rest hold
  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input logic [1:0] lg,
                                                input logic pg);
    logic [COL_W-1:0] m;
    m = pg ? {COL_W{1'b1}} : ((COL_W'(1) << lg) - COL_W'(1));
    return (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction

  logic              busy_q, page_q, ap_q;
  logic [1:0]        lg_q;
  logic [3:0]        left_q;
  logic [COL_W-1:0]  col_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic              cont;
  logic              st_single;

  assign cont      = busy_q & ~start & ~stop;
  assign st_single = ~code_is_page(st_code) && code_beats(st_code) == 4'd1;
  assign beat_vld  = start | cont;
  assign beat_col  = start ? st_col  : step_col(col_q, lg_q, page_q);
  assign beat_bank = start ? st_bank : bank_q;
  assign beat_row  = start ? st_row  : row_q;
  assign beat_ap   = start ? st_ap   : ap_q;
  assign beat_last = start ? st_single : (cont && !page_q && left_q == 4'd1);
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      page_q <= 1'b0;
      ap_q   <= 1'b0;
      lg_q   <= '0;
      left_q <= '0;
      col_q  <= '0;
      bank_q <= '0;
      row_q  <= '0;
    end else if (start) begin
      busy_q <= ~st_single;
      page_q <= code_is_page(st_code);
      lg_q   <= code_log(st_code);
      left_q <= code_beats(st_code) - 4'd1;
      ap_q   <= st_ap;
      col_q  <= st_col;
      bank_q <= st_bank;
      row_q  <= st_row;
    end else if (stop) begin
      busy_q <= 1'b0;
    end else if (cont) begin
      col_q  <= beat_col;
      left_q <= left_q - 4'd1;
      if (beat_last) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wb_beat_out.sv
module wb_beat_out #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int DQ_W   = 32,
  parameter int LANES  = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DQ_W-1:0]   dq,
  input  logic [LANES-1:0]  dqm,
  input  logic              pre,
  input  logic [BANK_W-1:0] pbank,
  input  logic              err,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DQ_W-1:0]   wr_data,
  output logic [LANES-1:0]  wr_be,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank,
  output logic              wr_err
);

  logic [DQ_W-1:0] masked;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign masked[gl*8 +: 8] = dqm[gl] ? 8'h00 : dq[gl*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_bank  <= '0;
      wr_row   <= '0;
      wr_col   <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
      pre_req  <= 1'b0;
      pre_bank <= '0;
      wr_err   <= 1'b0;
    end else begin
      wr_en    <= vld;
      wr_bank  <= bank;
      wr_row   <= row;
      wr_col   <= col;
      wr_data  <= vld ? masked : '0;
      wr_be    <= vld ? ~dqm : '0;
      pre_req  <= pre;
      pre_bank <= pbank;
      wr_err   <= err;
    end
  end

endmodule

// File: rtl/sdr_wb_engine.sv
module sdr_wb_engine
  import sdr_wb_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int DQ_W   = 32,
  parameter int BANK_W = $clog2(BANKS),
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int LANES  = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              auto_pre,
  input  logic [2:0]        bl_code,
  input  logic [DQ_W-1:0]   dq,
  input  logic [LANES-1:0]  dqm,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [DQ_W-1:0]   wr_data,
  output logic [LANES-1:0]  wr_be,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank,
  output logic              wr_err
);

  wb_cmd_e cmd_v;
  assign cmd_v = wb_cmd_e'(cmd);

  // named events for the checker
  logic                   act_hit, wr_hit, bst_hit, wr_accept, wr_reject;
  logic [BANKS-1:0]       open_vec;
  logic [BANKS*ROW_W-1:0] row_flat;
  logic [ROW_W-1:0]       cur_row;
  logic                   beat_vld, beat_last, beat_ap, seq_busy, close_go;
  logic [BANK_W-1:0]      beat_bank;
  logic [ROW_W-1:0]       beat_row;
  logic [COL_W-1:0]       beat_col;

  assign act_hit   = cmd_v == CMD_ACT;
  assign wr_hit    = cmd_v == CMD_WR;
  assign bst_hit   = cmd_v == CMD_BST;
  assign wr_accept = wr_hit &  open_vec[bank];
  assign wr_reject = wr_hit & ~open_vec[bank];
  assign close_go  = beat_vld & beat_last & beat_ap;

  always_comb begin
    cur_row = '0;
    for (int i = 0; i < BANKS; i++)
      if (BANK_W'(i) == bank) cur_row = row_flat[i*ROW_W +: ROW_W];
  end

  wb_row_track #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_hit), .act_bank(bank), .act_row(addr[ROW_W-1:0]),
    .close_en(close_go), .close_bank(beat_bank),
    .open_vec(open_vec), .row_flat(row_flat)
  );

  wb_burst_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(wr_accept), .stop(bst_hit),
    .st_bank(bank), .st_row(cur_row), .st_col(addr[COL_W-1:0]),
    .st_code(bl_code), .st_ap(auto_pre),
    .beat_vld(beat_vld), .beat_last(beat_last), .beat_ap(beat_ap),
    .beat_bank(beat_bank), .beat_row(beat_row), .beat_col(beat_col),
    .busy(seq_busy)
  );

  wb_beat_out #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n),
    .vld(beat_vld), .bank(beat_bank), .row(beat_row), .col(beat_col),
    .dq(dq), .dqm(dqm), .pre(close_go), .pbank(beat_bank), .err(wr_reject),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .wr_be(wr_be), .pre_req(pre_req), .pre_bank(pre_bank),
    .wr_err(wr_err)
  );

endmodule

// File: rtl/sdr_wb_engine_chk.sv
module sdr_wb_engine_chk #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DQ_W   = 32,
  parameter int ADDR_W = 11,
  parameter int LANES  = DQ_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_accept,
  input logic              wr_reject,
  input logic              busy,
  input logic              wr_en,
  input logic [BANK_W-1:0] wr_bank,
  input logic [COL_W-1:0]  wr_col,
  input logic [DQ_W-1:0]   wr_data,
  input logic [LANES-1:0]  wr_be,
  input logic              pre_req,
  input logic [BANK_W-1:0] pre_bank,
  input logic              wr_err
);

  logic [DQ_W-1:0] keep;
  always_comb
    for (int i = 0; i < LANES; i++) keep[i*8 +: 8] = {8{wr_be[i]}};

  AST_WRITE_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (wr_en && wr_col == $past(addr[COL_W-1:0]) && wr_bank == $past(bank))); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_accept) |=> !wr_en); // R4

  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~keep) == '0)); // R7

  AST_TERM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b11) |=> !wr_en); // R8

  AST_PRE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> (wr_en && pre_bank == wr_bank)); // R9

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> (wr_err && !$past(busy) == !wr_en)); // R10

endmodule

bind sdr_wb_engine sdr_wb_engine_chk #(
  .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr),
  .wr_accept(wr_accept), .wr_reject(wr_reject), .busy(seq_busy),
  .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
  .wr_be(wr_be), .pre_req(pre_req), .pre_bank(pre_bank), .wr_err(wr_err)
);

// File: tb/sdr_wb_engine_test.sv
module sdr_wb_engine_test;

  typedef struct packed {
    logic        en;
    logic [1:0]  bank;
    logic [10:0] row;
    logic [7:0]  col;
    logic [31:0] data;
    logic [3:0]  be;
    logic        pre;
    logic [1:0]  pbank;
    logic        err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [1:0]  bank = '0;
  logic [10:0] addr = '0;
  logic        auto_pre = 1'b0;
  logic [2:0]  bl_code = '0;
  logic [31:0] dq = '0;
  logic [3:0]  dqm = '0;
  logic        wr_en, pre_req, wr_err;
  logic [1:0]  wr_bank, pre_bank;
  logic [10:0] wr_row;
  logic [7:0]  wr_col;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  exp_t  exp_q[$];
  string req_q[$];

  // bench model state
  bit        m_open[4];
  int        m_rowv[4];
  bit        m_act = 0, m_full = 0, m_ap = 0;
  int        m_bank = 0, m_row = 0, m_base = 0, m_i = 0, m_len = 1;

  sdr_wb_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr),
    .auto_pre(auto_pre), .bl_code(bl_code), .dq(dq), .dqm(dqm),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .wr_be(wr_be), .pre_req(pre_req), .pre_bank(pre_bank),
    .wr_err(wr_err)
  );

  always #5 clk = ~clk;

  function automatic int beat_col(int base, int i, int len, bit full);
    if (full) return (base + i) % 256;
    return (base - base % len) + ((base % len + i) % len);
  endfunction

  function automatic logic [31:0] mask_word(logic [31:0] d, logic [3:0] m);
    logic [31:0] r = d;
    for (int k = 0; k < 4; k++) if (m[k]) r[k*8 +: 8] = 8'h00;
    return r;
  endfunction

  task automatic emit(ref exp_t e, input logic [31:0] d, input logic [3:0] m);
    e.en   = 1'b1;
    e.bank = 2'(m_bank);
    e.row  = 11'(m_row);
    e.col  = 8'(beat_col(m_base, m_i, m_len, m_full));
    e.data = mask_word(d, m);
    e.be   = ~m;
    if (!m_full && m_i == m_len - 1) begin
      m_act = 0;
      if (m_ap) begin
        e.pre = 1'b1;
        e.pbank = 2'(m_bank);
        m_open[m_bank] = 0;
      end
    end
  endtask

  task automatic step(input logic [1:0] c, input int b, input int a, input bit ap,
                      input int blc, input logic [31:0] d, input logic [3:0] m,
                      input string req);
    exp_t e;
    e = '0;
    @(negedge clk);
    cmd = c; bank = 2'(b); addr = 11'(a); auto_pre = ap; bl_code = 3'(blc);
    dq = d; dqm = m;
    if (c == 2'b10 && !m_open[b]) e.err = 1'b1;
    if (c == 2'b10 && m_open[b]) begin
      m_bank = b; m_row = m_rowv[b]; m_base = a % 256; m_i = 0;
      m_full = blc[2]; m_len = 1 << (blc % 4); m_ap = ap; m_act = 1;
      emit(e, d, m);
    end else if (c == 2'b11) begin
      m_act = 0;
    end else if (m_act) begin
      m_i++;
      emit(e, d, m);
    end
    if (c == 2'b01) begin
      m_open[b] = 1;
      m_rowv[b] = a;
    end
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic nop(input int n, input string req);
    for (int k = 0; k < n; k++)
      step(2'b00, 0, 0, 0, 0, 32'hDEAD_0000 + 32'(k), 4'h0, req);
  endtask

  // monitor: compare each pushed expectation one edge later
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e, g;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      g.en = wr_en; g.bank = wr_bank; g.row = wr_row; g.col = wr_col;
      g.data = wr_data; g.be = wr_be; g.pre = pre_req; g.pbank = pre_bank; g.err = wr_err;
      if (!g.en) begin g.bank = '0; g.row = '0; g.col = '0; g.data = '0; g.be = '0; end
      if (!g.pre) g.pbank = '0;
      tests++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s actual en=%0b b=%0d row=%h col=%h d=%h be=%h pre=%0b pb=%0d err=%0b expected en=%0b b=%0d row=%h col=%h d=%h be=%h pre=%0b pb=%0d err=%0b",
                 r, g.en, g.bank, g.row, g.col, g.data, g.be, g.pre, g.pbank, g.err,
                 e.en, e.bank, e.row, e.col, e.data, e.be, e.pre, e.pbank, e.err);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_open[k] = 0; m_rowv[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++; // R11 reset state
    if (wr_en !== 1'b0 || pre_req !== 1'b0 || wr_err !== 1'b0) begin
      fails++;
      $display("FAIL R11 actual en=%0b pre=%0b err=%0b expected 0 0 0", wr_en, pre_req, wr_err);
    end
    rst_n = 1'b1;

    // R11 / R10: no bank open after reset
    step(2'b10, 0, 8'h10, 0, 2, 32'h1111_1111, 4'h0, "R11");
    // open rows
    step(2'b01, 0, 11'h123, 0, 0, 0, 0, "R1");
    step(2'b01, 1, 11'h7FF, 0, 0, 0, 0, "R1");
    // R1 R2 R3: 4-beat burst wrapping at 0x0E
    step(2'b10, 0, 8'h0E, 0, 2, 32'hA000_0000, 4'h0, "R1");
    for (int k = 1; k < 4; k++) step(2'b00, 0, 0, 0, 0, 32'hA000_0000 + 32'(k), 4'h0, "R3");
    nop(3, "R4");
    // R7: 8-beat burst with byte masks
    step(2'b10, 1, 8'h35, 0, 3, 32'h1234_5678, 4'b0001, "R7");
    for (int k = 1; k < 8; k++)
      step(2'b00, 0, 0, 0, 0, 32'hCAFE_0000 + 32'(k), 4'(k), "R7");
    nop(2, "R4");
    // R2: single beat
    step(2'b10, 1, 8'h10, 0, 0, 32'h0BAD_F00D, 4'h0, "R2");
    nop(2, "R4");
    // R9: 2-beat auto precharge, then R10 on the closed bank
    step(2'b10, 0, 8'h41, 1, 1, 32'h5555_0000, 4'h0, "R9");
    step(2'b00, 0, 0, 0, 0, 32'h5555_0001, 4'h0, "R9");
    step(2'b10, 0, 8'h20, 0, 0, 32'h6666_6666, 4'h0, "R10");
    step(2'b01, 0, 11'h0AA, 0, 0, 0, 0, "R9");
    // R5 R8: full page across column 255, then terminate
    step(2'b10, 0, 8'hFD, 0, 7, 32'h7700_0000, 4'h0, "R5");
    for (int k = 1; k < 6; k++) step(2'b00, 0, 0, 0, 0, 32'h7700_0000 + 32'(k), 4'h0, "R5");
    step(2'b11, 0, 0, 0, 0, 32'hBBBB_BBBB, 4'h0, "R8");
    nop(2, "R8");
    // R6 + R9: truncated auto-precharge burst requests nothing
    step(2'b10, 0, 8'h80, 1, 3, 32'h8800_0000, 4'h0, "R6");
    step(2'b00, 0, 0, 0, 0, 32'h8800_0001, 4'h0, "R6");
    step(2'b10, 1, 8'h02, 0, 1, 32'h9900_0000, 4'h0, "R6");
    step(2'b10, 1, 8'h07, 0, 0, 32'h9900_0001, 4'h0, "R6");
    nop(2, "R6");
    // R10: rejected write during a burst does not disturb it
    step(2'b10, 1, 8'h30, 0, 2, 32'hC000_0000, 4'h0, "R10");
    step(2'b10, 2, 8'h00, 0, 0, 32'hC000_0001, 4'h0, "R10");
    step(2'b00, 0, 0, 0, 0, 32'hC000_0002, 4'h0, "R10");
    step(2'b00, 0, 0, 0, 0, 32'hC000_0003, 4'h0, "R10");
    nop(2, "R4");
    // random mix
    step(2'b01, 2, 11'h155, 0, 0, 0, 0, "R2");
    step(2'b01, 3, 11'h2AA, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 300; k++) begin
      int rc;
      logic [1:0] c;
      rc = $urandom % 10;
      c = (rc < 4) ? 2'b00 : (rc < 7) ? 2'b10 : (rc < 9) ? 2'b01 : 2'b11;
      step(c, $urandom % 4, $urandom % 2048, 1'($urandom % 2), $urandom % 8,
           $urandom, 4'($urandom), "R6");
    end
    nop(3, "R4");
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule